// File: doc/BRIEF.md
# Chained Two-Channel Free-Running Counter

This block joins two 16-bit timer channels into a single free-running 32-bit counter for use as a time base. The low channel counts at a rate picked by a clock-select input. That rate is either a master-clock division or a slow tick of about 32 kHz that the chip supplies as a one-cycle enable. The low channel also produces a square wave from two compare values, A and C. The wave goes high when the count reaches A and low when it reaches C. The high channel counts the rising edges of that wave.

With A at 0 and C at half range, the wave rises once per wrap of the low counter. The two counts then concatenate into one 32-bit value. Software turns each channel on and off with one-cycle commands. A block-wide sync command restarts both counters together.

Everything runs on one clock. The prescaled rate and the chained edge are single-cycle count enables. Both halves change on the same edge when the low half wraps, so reading high, then low, then high again gives a consistent value.

Top module: `cascade_counter32`

## Requirements
- R1: After reset both counts are 0, the wave output is low, and both channels are stopped, so no count changes until an enable command arrives.
- R2: A sync command clears both counters, the wave and the prescaler on the next edge. Sync takes priority over any count that would happen on that edge.
- R3: A channel starts counting after its enable command and stops after its disable command. Each command takes effect from the edge after the one that samples it. When enable and disable arrive together, disable wins.
- R4: Clock-select value k below NDIV advances the low counter once every 2^(DIV_BASE_LOG + DIV_STEP_LOG*k) cycles. The first advance falls on that many edges after a sync. Value NDIV advances the low counter once for each cycle in which the slow tick is high. Larger values give no advance.
- R5: The low counter runs from 0 to all ones and wraps to 0. Compare C never resets it.
- R6: The wave goes high on the edge where the low count enters compare A. It goes low on the edge where the low count enters compare C. If A equals C, the clear wins. Sync forces the wave low.
- R7: When its channel is enabled, the high counter increments on the same edge on which the wave rises. The 32-bit output is the high count in the upper half and the low count in the lower half.
- R8: With both channels running and A = 0, the 32-bit output changes by 0 or +1 (modulo 2^32) on every edge other than a sync. A high-low-high read that sees equal high values therefore returns a true value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | SEL_W | Low channel rate select; NDIV picks the slow tick |
| slow_tick | input | 1 | One-cycle enable at the slow rate |
| lo_en_cmd | input | 1 | Start the low channel |
| lo_dis_cmd | input | 1 | Stop the low channel |
| hi_en_cmd | input | 1 | Start the high channel |
| hi_dis_cmd | input | 1 | Stop the high channel |
| sync_cmd | input | 1 | Restart both counters together |
| cmp_a | input | CW | Count value that raises the wave |
| cmp_c | input | CW | Count value that lowers the wave |
| lo_count | output | CW | Low channel count |
| hi_count | output | CW | High channel count |
| lo_wave | output | 1 | Square-wave output of the low channel |
| count32 | output | 2*CW | Concatenated high and low counts |

## Verification
The bench builds the block with CW = 4, NDIV = 3, DIV_BASE_LOG = 1 and DIV_STEP_LOG = 1. This gives a 4-bit half, an 8-bit combined value and divisors of 2, 4 and 8. At these values a run of a few thousand cycles covers many low wraps and a full wrap of the combined value. It also covers the wave edges at count 0 and count 8 and the slow-tick path, so that each divisor and each chaining corner can be checked against an arithmetic model.

// File: rtl/cascade_counter32.sv
module cascade_counter32 #(
  parameter int CW           = 16,
  parameter int NDIV         = 4,
  parameter int DIV_BASE_LOG = 1,
  parameter int DIV_STEP_LOG = 2,
  localparam int PRE_W = DIV_BASE_LOG + DIV_STEP_LOG * (NDIV - 1),
  localparam int SEL_W = $clog2(NDIV + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] clk_sel,
  input  logic             slow_tick,
  input  logic             lo_en_cmd,
  input  logic             lo_dis_cmd,
  input  logic             hi_en_cmd,
  input  logic             hi_dis_cmd,
  input  logic             sync_cmd,
  input  logic [CW-1:0]    cmp_a,
  input  logic [CW-1:0]    cmp_c,
  output logic [CW-1:0]    lo_count,
  output logic [CW-1:0]    hi_count,
  output logic             lo_wave,
  output logic [2*CW-1:0]  count32
);

  logic [PRE_W-1:0] pre_cnt;
  logic [NDIV:0]    tick_vec;
  logic             sel_tick, lo_tick, hi_tick;
  logic             lo_run, hi_run;
  logic [CW-1:0]    lo_next;
  logic             wave_d;

  for (genvar k = 0; k < NDIV; k++) begin : g_div
    localparam int B = DIV_BASE_LOG + DIV_STEP_LOG * k;
    assign tick_vec[k] = &pre_cnt[B-1:0];
  end
  assign tick_vec[NDIV] = slow_tick;

  always_comb begin
    sel_tick = 1'b0;
    for (int k = 0; k <= NDIV; k++)
      if (clk_sel == SEL_W'(k)) sel_tick = tick_vec[k];
  end

  assign lo_tick = lo_run & sel_tick;
  assign lo_next = lo_count + 1'b1;

  always_comb begin
    wave_d = lo_wave;
    if (lo_tick) begin
      if (lo_next == cmp_c)      wave_d = 1'b0;
      else if (lo_next == cmp_a) wave_d = 1'b1;
    end
  end

  assign hi_tick = hi_run & wave_d & ~lo_wave;
  assign count32 = {hi_count, lo_count};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_run <= 1'b0;
      hi_run <= 1'b0;
    end else begin
      if (lo_dis_cmd)     lo_run <= 1'b0;
      else if (lo_en_cmd) lo_run <= 1'b1;
      if (hi_dis_cmd)     hi_run <= 1'b0;
      else if (hi_en_cmd) hi_run <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      lo_count <= '0;
      hi_count <= '0;
      lo_wave  <= 1'b0;
    end else if (sync_cmd) begin
      pre_cnt  <= '0;
      lo_count <= '0;
      hi_count <= '0;
      lo_wave  <= 1'b0;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
      if (lo_tick) lo_count <= lo_next;
      lo_wave <= wave_d;
      if (hi_tick) hi_count <= hi_count + 1'b1;
    end
  end

  a_r2_sync_clears: assert property (@(posedge clk) disable iff (!rst_n)
    sync_cmd |=> (lo_count == '0 && hi_count == '0 && !lo_wave));

  a_r3_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!lo_run && !sync_cmd) |=> $stable(lo_count));

  a_r6_wave_rise_at_a: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_tick && !sync_cmd && lo_next == cmp_a && cmp_a != cmp_c) |=> lo_wave);

  a_r7_hi_steps_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_cmd && !(lo_wave == 1'b0 && wave_d == 1'b1)) |=> $stable(hi_count));

  a_r8_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_cmd && lo_run && hi_run && cmp_a == '0 && cmp_c != '0 && $stable(cmp_a)) |=>
      (count32 == $past(count32) || count32 == (2*CW)'($past(count32) + 1'b1)));

endmodule

// File: tb/cascade_counter32_tb.sv
module cascade_counter32_tb;
  localparam int CW = 4;
  localparam int NDIV = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] clk_sel = '0;
  logic slow_tick = 0, lo_en_cmd = 0, lo_dis_cmd = 0, hi_en_cmd = 0, hi_dis_cmd = 0, sync_cmd = 0;
  logic [CW-1:0] cmp_a = 4'd0, cmp_c = 4'd8;
  logic [CW-1:0] lo_count, hi_count;
  logic lo_wave;
  logic [2*CW-1:0] count32;

  int checks = 0, fails = 0;

  cascade_counter32 #(.CW(CW), .NDIV(NDIV), .DIV_BASE_LOG(1), .DIV_STEP_LOG(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .slow_tick(slow_tick),
    .lo_en_cmd(lo_en_cmd), .lo_dis_cmd(lo_dis_cmd), .hi_en_cmd(hi_en_cmd),
    .hi_dis_cmd(hi_dis_cmd), .sync_cmd(sync_cmd), .cmp_a(cmp_a), .cmp_c(cmp_c),
    .lo_count(lo_count), .hi_count(hi_count), .lo_wave(lo_wave), .count32(count32));

  always #2 clk = ~clk;

  // {clk_sel, edges after sync, expected count32}; count = floor(edges/divisor) mod 256
  localparam logic [21:0] VEC [6] = '{
    {2'd0, 12'd40,   8'd20},
    {2'd1, 12'd100,  8'd25},
    {2'd2, 12'd300,  8'd37},
    {2'd0, 12'd600,  8'd44},
    {2'd2, 12'd2100, 8'd6},
    {2'd1, 12'd1030, 8'd1}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_sync();
    @(negedge clk) sync_cmd = 1;
    @(negedge clk) sync_cmd = 0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: begin lo_en_cmd = 1; hi_en_cmd = 1; end
      1: begin lo_dis_cmd = 1; hi_dis_cmd = 1; end
      2: begin lo_en_cmd = 1; lo_dis_cmd = 1; hi_en_cmd = 1; hi_dis_cmd = 1; end
      3: begin lo_en_cmd = 1; hi_dis_cmd = 1; end
      default: ;
    endcase
    @(negedge clk);
    lo_en_cmd = 0; lo_dis_cmd = 0; hi_en_cmd = 0; hi_dis_cmd = 0;
  endtask

  initial begin
    #(4ns * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v, prev;
    int bad;
    #10 rst_n = 1;
    @(negedge clk);
    chk("R1 reset count32", count32, 0);
    chk("R1 reset wave", lo_wave, 0);
    run(20);
    chk("R1 stopped until enabled", count32, 0);

    pulse(0);
    foreach (VEC[i]) begin
      clk_sel = VEC[i][21:20];
      do_sync();
      run(int'(VEC[i][19:8]));
      chk($sformatf("R4 R7 vector %0d", i), count32, int'(VEC[i][7:0]));
    end

    clk_sel = 0;
    do_sync(); run(6);
    chk("R6 wave low before wrap", lo_wave, 0);
    do_sync(); run(40);
    chk("R5 low wraps", lo_count, 4);
    chk("R6 wave high after entering A", lo_wave, 1);
    chk("R7 high counts wave rise", hi_count, 1);
    do_sync(); run(50);
    chk("R6 wave low after entering C", lo_wave, 0);

    cmp_a = 4'd3; cmp_c = 4'd10;
    do_sync(); run(10);
    chk("R6 wave rises at A=3", lo_wave, 1);
    chk("R7 high steps at A=3", hi_count, 1);
    cmp_a = 4'd5; cmp_c = 4'd5;
    do_sync(); run(40);
    chk("R6 clear wins when A equals C", lo_wave, 0);
    chk("R7 no rise no high step", hi_count, 0);
    cmp_a = 4'd0; cmp_c = 4'd8;

    do_sync(); run(20);
    chk("R2 sync before", count32, 10);
    do_sync();
    chk("R2 sync clears", count32, 0);

    run(20);
    pulse(1);
    v = count32;
    run(30);
    chk("R3 disable holds count", count32, v);
    pulse(2);
    run(30);
    chk("R3 disable wins over enable", count32, v);

    pulse(3);
    do_sync(); run(40);
    chk("R7 high disabled stays", hi_count, 0);
    chk("R7 low keeps counting", lo_count, 4);

    pulse(0);
    clk_sel = 2'd3;
    do_sync();
    for (int k = 0; k < 5; k++) begin
      @(negedge clk) slow_tick = 1;
      @(negedge clk) slow_tick = 0;
      run(3);
    end
    chk("R4 slow tick count", count32, 5);

    clk_sel = 0;
    do_sync();
    bad = 0;
    prev = count32;
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      v = count32;
      if (v != prev && v != 8'(prev + 1)) bad++;
      prev = v;
    end
    chk("R8 monotonic steps", bad, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule